// File: doc/BRIEF.md
# Transmit-Only Two-Wire Serial Master

This block drives a two-wire bus (a clock line and a data line) as a master that only sends. A one-cycle start pulse launches a transfer. The block captures the byte count and the divider value at that moment and issues a start condition. It then requests bytes one at a time from an external buffer through a single-cycle read strobe and shifts each byte out on the data line. It ends with a stop condition and returns to idle. A status output is high while the engine is idle and low while a transfer is under way.

The bus has no acknowledge slot, no address phase, no receive path, no clock stretching and no arbitration. Each byte takes exactly eight clock pulses. The buffer must present the requested byte on `rd_data_i` combinationally in the same cycle as the strobe. The engine samples it at the clock edge that ends that cycle.

Top module: `wo_serial_tx`

## Requirements
- R1: Out of reset and whenever the engine is idle, `scl_o` and `sda_o` are high, `status_o` is high and `rd_o` is low.
- R2: In the cycle after an accepted start pulse, `status_o` is low, `sda_o` is low and `scl_o` is high. `scl_o` falls exactly 2*D system clocks later, where D is the effective divider.
- R3: Each byte is sent most significant bit first as eight bit periods of 2*D clocks each. In every bit period `scl_o` is low for the first D clocks and high for the last D clocks, and there is no ninth pulse.
- R4: `sda_o` takes its new value SDA_DLY clocks after each falling edge of `scl_o` (default 1). It never changes while `scl_o` is high during a transfer, except at the start and stop conditions.
- R5: `rd_o` pulses for one cycle in the last cycle of the start period and in the last cycle of each byte's final bit, as long as bytes remain. The byte on `rd_data_i` in that cycle is the next byte sent. A transfer issues exactly N strobes, where N is the byte count.
- R6: After the last bit, `scl_o` stays low for D clocks, with `sda_o` driven low SDA_DLY clocks into that time. `scl_o` then rises. `sda_o` rises 2*D clocks after `scl_o` rises, and `status_o` goes high in the same cycle.
- R7: A byte count of 0 produces the start period followed directly by the stop sequence, with no read strobe.
- R8: A divider value of 0 or 1 is treated as 2. Otherwise D equals `clk_div_i`.
- R9: The byte count and the divider are captured when a start is accepted. Changes to them during a transfer have no effect on that transfer.
- R10: A start pulse that arrives while a transfer is in progress is ignored.
- R11: For GAP_CYC clocks after `status_o` returns high (default 16), start pulses are ignored. This enforces the minimum bus-free time.
- R12: The byte count is 7 bits wide, and a transfer of 127 bytes completes correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| num_i | input | 7 | Number of bytes to send |
| clk_div_i | input | 6 | Half bit period in system clocks (minimum 2) |
| rd_data_i | input | 8 | Byte from the buffer, valid in the strobe cycle |
| scl_o | output | 1 | Serial clock line |
| sda_o | output | 1 | Serial data line |
| rd_o | output | 1 | Buffer read strobe |
| status_o | output | 1 | High when idle, low while busy |

## Verification
The hardest situations to reach are the edges where phases meet. These are the end of a byte with further bytes pending, the last byte handing over to the stop sequence, and the start period with a zero count. At each of these points the strobe, the bit counter and the data line must all agree in a single cycle. The stimulus reaches them by running transfers across several divider values, including the clamped values and the largest divider, and with byte counts of 0, 1, several and 127. It also toggles the start input and the configuration inputs while a transfer is running and in the first cycle after idle returns. A behavioural reference model computes the expected level of every output from the elapsed cycle count. Every cycle is compared against it, so a slip of one cycle at any phase boundary shows up as a mismatch.

// File: rtl/wo_tx_pkg.sv
package wo_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WORK  = 2'd2,
    ST_STOP  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/wo_tx_timer.sv
module wo_tx_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] lim_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == lim_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || wrap_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/wo_tx_byteseq.sv
module wo_tx_byteseq #(
  parameter int DATA_W = 8,
  parameter int NUM_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [NUM_W-1:0]  num_i,
  output logic              cur_bit_o,
  output logic              last_bit_o,
  output logic              more_o
);
  localparam int BW = $clog2(DATA_W);

  logic [DATA_W-1:0] byte_q;
  logic [BW-1:0]     bit_q;
  logic [NUM_W-1:0]  fetched_q;

  assign cur_bit_o  = byte_q[bit_q];
  assign last_bit_o = (bit_q == '0);
  assign more_o     = (fetched_q < num_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q    <= '0;
      bit_q     <= '0;
      fetched_q <= '0;
    end else begin
      if (clr_i) fetched_q <= '0;
      else if (load_i) fetched_q <= fetched_q + NUM_W'(1);
      if (load_i) begin
        byte_q <= rd_data_i;
        bit_q  <= BW'(DATA_W - 1);
      end else if (step_i) begin
        bit_q  <= bit_q - BW'(1);
      end
    end
  end
endmodule

// File: rtl/wo_tx_ctrl.sv
module wo_tx_ctrl
  import wo_tx_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int NUM_W   = 7,
  parameter int CW      = DIV_W + 2,
  parameter int SDA_DLY = 1,
  parameter int GAP_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             wrap_i,
  input  logic             cur_bit_i,
  input  logic             last_bit_i,
  input  logic             more_i,
  output logic             run_o,
  output logic [CW-1:0]    lim_o,
  output logic             clr_o,
  output logic             load_o,
  output logic             step_o,
  output logic [NUM_W-1:0] num_q_o,
  output logic             scl_o,
  output logic             sda_o,
  output logic             status_o
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] DLY_AT = CW'(SDA_DLY - 1);

  tx_state_e        state_q, state_d;
  logic [DIV_W-1:0] div_q;
  logic [NUM_W-1:0] num_q;
  logic [GW-1:0]    gap_q;
  logic             sda_q;
  logic [CW-1:0]    d;

  assign d        = CW'(div_q);
  assign clr_o    = (state_q == ST_IDLE) && (gap_q == '0) && start_i;
  assign run_o    = (state_q != ST_IDLE);
  assign lim_o    = (state_q == ST_STOP) ? (d + d + d - CW'(1)) : (d + d - CW'(1));
  assign step_o   = (state_q == ST_WORK) && wrap_i;
  assign load_o   = wrap_i && more_i &&
                    ((state_q == ST_START) || ((state_q == ST_WORK) && last_bit_i));
  assign num_q_o  = num_q;
  assign status_o = (state_q == ST_IDLE);
  assign sda_o    = sda_q;

  always_comb begin
    unique case (state_q)
      ST_IDLE, ST_START: scl_o = 1'b1;
      default:           scl_o = (cnt_i >= d);
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (clr_o) state_d = ST_START;
      ST_START: if (wrap_i) state_d = more_i ? ST_WORK : ST_STOP;
      ST_WORK:  if (wrap_i && last_bit_i && !more_i) state_d = ST_STOP;
      ST_STOP:  if (wrap_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= DIV_W'(2);
      num_q   <= '0;
      gap_q   <= '0;
      sda_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      if (clr_o) begin
        div_q <= (clk_div_i < DIV_W'(2)) ? DIV_W'(2) : clk_div_i;
        num_q <= num_i;
        sda_q <= 1'b0;
      end else if ((state_q == ST_WORK) && (cnt_i == DLY_AT)) begin
        sda_q <= cur_bit_i;
      end else if (state_q == ST_STOP) begin
        if (wrap_i) sda_q <= 1'b1;
        else if (cnt_i == DLY_AT) sda_q <= 1'b0;
      end
      if ((state_q == ST_STOP) && wrap_i) gap_q <= GW'(GAP_CYC);
      else if ((state_q == ST_IDLE) && (gap_q != '0)) gap_q <= gap_q - GW'(1);
    end
  end
endmodule

// File: rtl/wo_serial_tx.sv
module wo_serial_tx #(
  parameter int DIV_W   = 6,
  parameter int NUM_W   = 7,
  parameter int DATA_W  = 8,
  parameter int SDA_DLY = 1,
  parameter int GAP_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_W-1:0]  num_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              scl_o,
  output logic              sda_o,
  output logic              rd_o,
  output logic              status_o
);
  localparam int CW = DIV_W + 2;

  logic             run, wrap, clr, step;
  logic             cur_bit, last_bit, more;
  logic [CW-1:0]    lim, cnt;
  logic [NUM_W-1:0] num_q;

  wo_tx_timer #(.CW(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .lim_i  (lim),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  wo_tx_byteseq #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .load_i     (rd_o),
    .step_i     (step),
    .rd_data_i  (rd_data_i),
    .num_i      (num_q),
    .cur_bit_o  (cur_bit),
    .last_bit_o (last_bit),
    .more_o     (more)
  );

  wo_tx_ctrl #(
    .DIV_W(DIV_W), .NUM_W(NUM_W), .CW(CW),
    .SDA_DLY(SDA_DLY), .GAP_CYC(GAP_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .num_i      (num_i),
    .clk_div_i  (clk_div_i),
    .cnt_i      (cnt),
    .wrap_i     (wrap),
    .cur_bit_i  (cur_bit),
    .last_bit_i (last_bit),
    .more_i     (more),
    .run_o      (run),
    .lim_o      (lim),
    .clr_o      (clr),
    .load_o     (rd_o),
    .step_o     (step),
    .num_q_o    (num_q),
    .scl_o      (scl_o),
    .sda_o      (sda_o),
    .status_o   (status_o)
  );
endmodule

// File: rtl/wo_serial_tx_chk.sv
module wo_serial_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_o,
  input logic sda_o,
  input logic rd_o,
  input logic status_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o |-> (scl_o && sda_o && !rd_o)); // R1

  AST_START_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $fell(status_o)) |-> (scl_o && !sda_o)); // R2

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && scl_o && $past(scl_o) && !status_o && !$past(status_o)) |-> $stable(sda_o)); // R4

  AST_RD_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> !rd_o); // R5

  AST_RD_IN_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (scl_o && !status_o)); // R5

  AST_STOP_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $rose(status_o)) |-> (scl_o && $past(scl_o) && !$past(sda_o))); // R6
endmodule

bind wo_serial_tx wo_serial_tx_chk u_chk (.*);

// File: tb/wo_serial_tx_tb.sv
module wo_serial_tx_tb;
  localparam int DLY = 1;
  localparam int GAP = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] num = '0;
  logic [5:0] clk_div = '0;
  logic [7:0] rd_data;
  logic       scl, sda, rd, status;

  logic [7:0] mem [0:127];
  int         rd_ptr = 0;
  int         vecs = 0, errs = 0, cyc = 0;
  bit         done = 0;
  string      tag = "R1";

  // reference model state
  bit m_busy = 0;
  int m_t = 0, m_gap = 0, m_d = 2, m_n = 0;

  always #5 clk = ~clk;

  assign rd_data = mem[rd_ptr & 127];

  wo_serial_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .num_i(num),
    .clk_div_i(clk_div), .rd_data_i(rd_data),
    .scl_o(scl), .sda_o(sda), .rd_o(rd), .status_o(status)
  );

  always @(posedge clk) if (rd) rd_ptr <= rd_ptr + 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_gap = 0;
    end else if (!m_busy) begin
      if (m_gap > 0) m_gap--;
      else if (start) begin
        m_busy = 1; m_t = 0;
        m_d = (clk_div < 2) ? 2 : int'(clk_div);
        m_n = int'(num);
      end
    end else begin
      m_t++;
      if (m_t == 2*m_d + 16*m_n*m_d + 3*m_d) begin
        m_busy = 0; m_gap = GAP;
      end
    end
  end

  function automatic logic bitv(int g);
    return mem[(g/8) & 127][7 - g%8];
  endfunction
  function automatic logic prevb(int g);
    return (g == 0) ? 1'b0 : bitv(g - 1);
  endfunction

  always @(negedge clk) begin : cmp
    int p, u, g, c;
    logic e_scl, e_sda, e_rd, e_st;
    if (rst_n && !done) begin
      p = 2*m_d;
      if (!m_busy) begin
        e_scl = 1; e_sda = 1; e_rd = 0; e_st = 1;
      end else if (m_t < p) begin
        e_scl = 1; e_sda = 0; e_rd = (m_t == p-1) && (m_n > 0); e_st = 0;
      end else if (m_t < p + 8*m_n*p) begin
        u = m_t - p; g = u / p; c = u % p;
        e_scl = (c >= m_d);
        e_sda = (c >= DLY) ? bitv(g) : prevb(g);
        e_rd  = (c == p-1) && (g%8 == 7) && (g/8 < m_n-1);
        e_st  = 0;
      end else begin
        c = m_t - p - 8*m_n*p;
        e_scl = (c >= m_d);
        e_sda = (c >= DLY) ? 1'b0 : prevb(8*m_n);
        e_rd = 0; e_st = 0;
      end
      vecs++;
      if (scl !== e_scl || sda !== e_sda || rd !== e_rd || status !== e_st) begin
        errs++;
        $display("FAIL [%s] t=%0d scl got %b exp %b, sda got %b exp %b, rd got %b exp %b, status got %b exp %b",
                 tag, m_t, scl, e_scl, sda, e_sda, rd, e_rd, status, e_st);
      end
    end
  end

  task automatic fill(int seed);
    for (int i = 0; i < 128; i++) mem[i] = 8'((i*37 + seed*11 + 5) ^ (i >> 1));
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
  endtask

  task automatic check_reads(int n);
    vecs++;
    if (rd_ptr != n) begin
      errs++;
      $display("FAIL [%s] strobe count got %0d exp %0d", tag, rd_ptr, n);
    end
  endtask

  task automatic xfer(int div, int n, int seed, string t);
    tag = t;
    fill(seed);
    @(negedge clk);
    clk_div = 6'(div); num = 7'(n); rd_ptr = 0; start = 1;
    @(negedge clk); start = 0;
    wait_idle();
    check_reads(n);
    repeat (GAP + 2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; errs++;
      $display("FAIL [watchdog] got timeout exp completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    // R1 reset state
    vecs++;
    if (scl !== 1 || sda !== 1 || rd !== 0 || status !== 1) begin
      errs++;
      $display("FAIL [R1] reset got %b%b%b%b exp 1101", scl, sda, rd, status);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);

    xfer(2, 1, 1, "R2 R3 R4 R5 R6");
    xfer(5, 3, 2, "R3 R4 R5 R6");
    xfer(3, 0, 3, "R7");
    xfer(0, 2, 4, "R8");
    xfer(1, 1, 5, "R8");
    xfer(63, 1, 6, "R3 R6 div63");
    xfer(2, 127, 7, "R12");

    // R9 R10: start and config changes while busy
    tag = "R9 R10"; fill(8);
    @(negedge clk); clk_div = 4; num = 2; rd_ptr = 0; start = 1;
    @(negedge clk); start = 0;
    repeat (15) @(negedge clk);
    start = 1; num = 9; clk_div = 11;
    @(negedge clk); start = 0;
    repeat (40) @(negedge clk);
    num = 1; clk_div = 2;
    wait_idle();
    check_reads(2);

    // R11: start in the first idle cycle is ignored
    tag = "R11";
    start = 1; num = 3; clk_div = 3;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    repeat (GAP + 4) @(negedge clk);
    check_reads(2);
    xfer(3, 2, 9, "R11 after gap");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule